// File: doc/BRIEF.md
# Cartridge Command-Mode Interpreter

This block sits on the cartridge side of a serial game-card link and interprets 8-byte commands. It tracks which of four command modes is active: raw after reset, one of two secure variants, or main. It also decides which opcode set applies in that mode. An opcode that belongs to another mode is treated as unknown, so a secure-mode command can never be misread as a raw-mode or main-mode opcode. Secure-mode commands reach the block already decrypted. Cipher work is left to a neighbour, which the block only asks to initialise its keys.

For every accepted command the block returns one response descriptor. The descriptor tells the data path one of four things:
- send nothing;
- fill the transfer with a constant byte;
- repeat the 32-bit chip identifier in every word;
- stream ROM from a start address, where the data wraps every `rsp_span` bytes when `rsp_span` is not zero.

The block also holds a sticky data-encryption flag.

Top module: `cart_cmd_fsm`

## Requirements
- R1: A synchronous active-high reset puts the block in raw mode (`mode` = 0) with `data_enc` = 0, `rsp_valid` = 0 and `key_init` = 0. `cmd_ready` is 1 from the first cycle after reset.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `rsp_valid` is 1 for exactly the cycle after each accepted command and is 0 otherwise. Mode codes are: 0 raw, 1 secure standard, 2 secure extended, 3 main. Response kinds are: 0 none, 1 fill, 2 chip ID, 3 ROM. Byte 0 of a command is `cmd_data[63:56]` and byte 2 is `cmd_data[47:40]`. For a none response, `rsp_addr`, `rsp_len` and `rsp_span` are 0.
- R3: In raw mode, opcode 0x9F gives kind fill with `rsp_fill` = 0xFF and `rsp_len` = `cmd_len`.
- R4: In raw mode, opcode 0x00 gives kind ROM with address 0, `rsp_len` = `cmd_len` and `rsp_span` = 0x1000, so the header repeats past 0x1000 bytes.
- R5: In raw mode, opcode 0x90 gives kind chip ID with `rsp_len` = `cmd_len`. Opcode 0xB8 in raw mode gives kind none.
- R6: In raw mode, opcode 0x3C moves to secure standard mode and pulses `key_init` with `key_ext` = 0, in the same cycle as `rsp_valid`.
- R7: In raw mode, opcode 0x3D with `ext_platform` = 1 moves to secure extended mode and pulses `key_init` with `key_ext` = 1. With `ext_platform` = 0 it gives kind none, changes no mode and raises no `key_init`.
- R8: In raw mode, any other opcode gives kind none and changes no state.
- R9: In either secure mode, a byte-0 upper nibble of 0x4 sets `data_enc` with kind none. `data_enc` stays 1 until reset, including after the move to main mode.
- R10: In either secure mode, a byte-0 upper nibble of 0x1 gives kind chip ID with `rsp_len` = `cmd_len`. Nibble 0x2 gives kind ROM with `rsp_len` = 0x1000, `rsp_span` = 0x1000 and address = (byte2 AND 0xF0) << 8.
- R11: In secure extended mode, the ROM address of R10 is reduced by 0x1000 and increased by `region_field` << 19, modulo 2^32.
- R12: In either secure mode, nibble 0xA moves to main mode. All other nibbles, including raw-mode opcodes such as 0x9F, give kind none with no mode change.
- R13: In main mode, opcode 0xB8 gives kind chip ID with `rsp_len` = `cmd_len`. Every other opcode, including 0x00, 0x90, 0x9F, 0x3C and secure-mode values, gives kind none. Main mode is left only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_data | input | 64 | Command bytes, byte 0 in bits 63:56 (secure commands already decrypted) |
| cmd_len | input | 16 | Requested transfer length in bytes |
| ext_platform | input | 1 | Host allows the extended secure mode |
| chip_id | input | 32 | Chip identifier used by chip-ID responses |
| region_field | input | 16 | Header field that places the extended secure region |
| rsp_valid | output | 1 | Response descriptor strobe |
| rsp_kind | output | 2 | 0 none, 1 fill, 2 chip ID, 3 ROM |
| rsp_fill | output | 8 | Fill byte for kind fill |
| rsp_addr | output | 32 | ROM start address |
| rsp_len | output | 16 | Transfer length in bytes |
| rsp_span | output | 16 | ROM wrap span, 0 for none |
| mode | output | 2 | Current command mode |
| data_enc | output | 1 | Data encryption enabled |
| key_init | output | 1 | One-cycle request to set up cipher keys |
| key_ext | output | 1 | Key set-up is for the extended variant |

## Verification
The hardest states to reach are the ones deep in the mode sequence. Examples are an extended-mode ROM read with a non-trivial region base, and a main-mode command whose opcode collides with a raw or secure opcode. A port can reach them only through an exact chain of mode-changing commands. The table-driven stimulus walks one long chain: raw, then secure, then main. Opcodes that belong to other modes are sent at every stage to confirm they decode to nothing. Directed sequences then reset the block, enter the extended variant with `ext_platform` raised and a non-unit region field, and check the wrapped address arithmetic.

// File: rtl/cart_cmd_pkg.sv
package cart_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_RAW     = 2'd0,
    MODE_SEC_STD = 2'd1,
    MODE_SEC_EXT = 2'd2,
    MODE_MAIN    = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    RSP_NONE   = 2'd0,
    RSP_FILL   = 2'd1,
    RSP_CHIPID = 2'd2,
    RSP_ROM    = 2'd3
  } kind_e;

  // Decision produced by one opcode decoder
  typedef struct packed {
    kind_e      kind;
    logic [7:0] fill;
    logic       len_fixed;  // length is one block instead of the request
    logic       wrap_blk;   // ROM data wraps every block
    logic       set_mode;
    mode_e      next_mode;
    logic       set_enc;
    logic       key_req;
    logic       key_ext;
  } dec_t;

  localparam dec_t DEC_NONE = '{
    kind: RSP_NONE, fill: 8'h00, len_fixed: 1'b0, wrap_blk: 1'b0,
    set_mode: 1'b0, next_mode: MODE_RAW, set_enc: 1'b0,
    key_req: 1'b0, key_ext: 1'b0
  };

endpackage

// File: rtl/cart_raw_dec.sv
module cart_raw_dec
  import cart_cmd_pkg::*;
#(
  parameter logic [7:0] OP_FILL   = 8'h9F,
  parameter logic [7:0] OP_HEADER = 8'h00,
  parameter logic [7:0] OP_ID     = 8'h90,
  parameter logic [7:0] OP_SEC    = 8'h3C,
  parameter logic [7:0] OP_SECX   = 8'h3D,
  parameter logic [7:0] FILL_BYTE = 8'hFF
) (
  input  logic [7:0] opcode,
  input  logic       ext_ok,
  output dec_t       dec
);

  always_comb begin
    dec = DEC_NONE;
    unique case (opcode)
      OP_FILL: begin
        dec.kind = RSP_FILL;
        dec.fill = FILL_BYTE;
      end
      OP_HEADER: begin
        dec.kind     = RSP_ROM;
        dec.wrap_blk = 1'b1;
      end
      OP_ID: dec.kind = RSP_CHIPID;
      OP_SEC: begin
        dec.set_mode  = 1'b1;
        dec.next_mode = MODE_SEC_STD;
        dec.key_req   = 1'b1;
      end
      OP_SECX: begin
        if (ext_ok) begin
          dec.set_mode  = 1'b1;
          dec.next_mode = MODE_SEC_EXT;
          dec.key_req   = 1'b1;
          dec.key_ext   = 1'b1;
        end
      end
      default: dec = DEC_NONE;
    endcase
  end

endmodule

// File: rtl/cart_sec_dec.sv
module cart_sec_dec
  import cart_cmd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BASE_W     = 16,
  parameter int BASE_SHIFT = 19,
  parameter int BLK_BYTES  = 4096
) (
  input  logic [3:0]        nib0,      // upper nibble of decrypted byte 0
  input  logic [3:0]        nib2,      // upper nibble of decrypted byte 2
  input  logic              ext_mode,
  input  logic [BASE_W-1:0] region,
  output dec_t              dec,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [3:0] NIB_ENC  = 4'h4;
  localparam logic [3:0] NIB_ID   = 4'h1;
  localparam logic [3:0] NIB_READ = 4'h2;
  localparam logic [3:0] NIB_MAIN = 4'hA;

  logic [ADDR_W-1:0] std_addr;
  logic [ADDR_W-1:0] region_base;

  assign std_addr    = ADDR_W'({nib2, 12'h000});
  assign region_base = ADDR_W'(region) << BASE_SHIFT;

  always_comb begin
    if (ext_mode)
      addr = std_addr - ADDR_W'(BLK_BYTES) + region_base;
    else
      addr = std_addr;
  end

  always_comb begin
    dec = DEC_NONE;
    unique case (nib0)
      NIB_ENC:  dec.set_enc = 1'b1;
      NIB_ID:   dec.kind    = RSP_CHIPID;
      NIB_READ: begin
        dec.kind      = RSP_ROM;
        dec.len_fixed = 1'b1;
        dec.wrap_blk  = 1'b1;
      end
      NIB_MAIN: begin
        dec.set_mode  = 1'b1;
        dec.next_mode = MODE_MAIN;
      end
      default: dec = DEC_NONE;
    endcase
  end

endmodule

// File: rtl/cart_main_dec.sv
module cart_main_dec
  import cart_cmd_pkg::*;
#(
  parameter logic [7:0] OP_ID = 8'hB8
) (
  input  logic [7:0] opcode,
  output dec_t       dec
);

  always_comb begin
    dec = DEC_NONE;
    if (opcode == OP_ID) dec.kind = RSP_CHIPID;
  end

endmodule

// File: rtl/cart_cmd_fsm.sv
module cart_cmd_fsm
  import cart_cmd_pkg::*;
#(
  parameter int CMD_W      = 64,
  parameter int LEN_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 32,
  parameter int BASE_W     = 16,
  parameter int BASE_SHIFT = 19,
  parameter int BLK_BYTES  = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              ext_platform,
  input  logic [ID_W-1:0]   chip_id,
  input  logic [BASE_W-1:0] region_field,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [7:0]        rsp_fill,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [LEN_W-1:0]  rsp_span,
  output logic [1:0]        mode,
  output logic              data_enc,
  output logic              key_init,
  output logic              key_ext
);

  localparam int B0_HI = CMD_W - 1;
  localparam int B2_HI = CMD_W - 17;
  localparam logic [LEN_W-1:0] BLK_LEN = LEN_W'(BLK_BYTES);

  mode_e             mode_q;
  logic              enc_q;
  logic              rdy_q;
  logic              fire;
  logic [7:0]        op_byte;
  dec_t              raw_d, sec_d, main_d, sel_d;
  logic [ADDR_W-1:0] sec_addr, sel_addr;

  assign op_byte = cmd_data[B0_HI -: 8];
  assign fire    = cmd_valid & rdy_q;

  cart_raw_dec u_raw (
    .opcode (op_byte),
    .ext_ok (ext_platform),
    .dec    (raw_d)
  );

  cart_sec_dec #(
    .ADDR_W     (ADDR_W),
    .BASE_W     (BASE_W),
    .BASE_SHIFT (BASE_SHIFT),
    .BLK_BYTES  (BLK_BYTES)
  ) u_sec (
    .nib0     (cmd_data[B0_HI -: 4]),
    .nib2     (cmd_data[B2_HI -: 4]),
    .ext_mode (mode_q == MODE_SEC_EXT),
    .region   (region_field),
    .dec      (sec_d),
    .addr     (sec_addr)
  );

  cart_main_dec u_main (
    .opcode (op_byte),
    .dec    (main_d)
  );

  // Only the decoder of the active mode is ever consulted
  always_comb begin
    sel_addr = '0;
    unique case (mode_q)
      MODE_RAW:     sel_d = raw_d;
      MODE_SEC_STD,
      MODE_SEC_EXT: begin
        sel_d    = sec_d;
        sel_addr = sec_addr;
      end
      MODE_MAIN:    sel_d = main_d;
      default:      sel_d = DEC_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_RAW;
      enc_q     <= 1'b0;
      rdy_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_kind  <= RSP_NONE;
      rsp_fill  <= '0;
      rsp_addr  <= '0;
      rsp_len   <= '0;
      rsp_span  <= '0;
      key_init  <= 1'b0;
      key_ext   <= 1'b0;
    end else begin
      rdy_q     <= 1'b1;
      rsp_valid <= fire;
      key_init  <= fire & sel_d.key_req;
      if (fire) begin
        rsp_kind <= sel_d.kind;
        rsp_fill <= sel_d.fill;
        key_ext  <= sel_d.key_ext;
        rsp_addr <= (sel_d.kind == RSP_ROM) ? sel_addr : '0;
        if (sel_d.kind == RSP_NONE)
          rsp_len <= '0;
        else if (sel_d.len_fixed)
          rsp_len <= BLK_LEN;
        else
          rsp_len <= cmd_len;
        rsp_span <= sel_d.wrap_blk ? BLK_LEN : '0;
        if (sel_d.set_mode) mode_q <= sel_d.next_mode;
        if (sel_d.set_enc)  enc_q  <= 1'b1;
      end
    end
  end

  assign cmd_ready = rdy_q;
  assign mode      = mode_q;
  assign data_enc  = enc_q;

endmodule

// File: rtl/cart_cmd_fsm_chk.sv
module cart_cmd_fsm_chk #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic [LEN_W-1:0]  rsp_len,
  input logic [1:0]        mode,
  input logic              data_enc,
  input logic              key_init
);

  logic fire;
  assign fire = cmd_valid & cmd_ready;

  // R2: a response follows each accepted command
  a_r2_rsp_after_cmd: assert property (@(posedge clk) disable iff (rst)
    fire |=> rsp_valid);

  // R2: no response without a command
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !rsp_valid);

  // R2 / R8: mode never moves without an accepted command
  a_r8_mode_holds_idle: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(mode));

  // R6 / R7: key request only on leaving raw mode into a secure mode
  a_r6_key_init_entry: assert property (@(posedge clk) disable iff (rst)
    key_init |-> (rsp_valid && (mode == 2'd1 || mode == 2'd2)));

  // R9: the encryption flag is sticky
  a_r9_enc_sticky: assert property (@(posedge clk) disable iff (rst)
    data_enc |=> data_enc);

  // R12 / R13: once out of raw mode, never back without reset
  a_r12_no_return_raw: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd0) |=> (mode != 2'd0));

  // R13: main mode is terminal
  a_r13_main_terminal: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3) |=> (mode == 2'd3));

  // R2: a none response carries no length
  a_r2_none_zero_len: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd0) |-> (rsp_len == '0));

endmodule

bind cart_cmd_fsm cart_cmd_fsm_chk #(
  .LEN_W  (LEN_W),
  .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/test_cart_cmd_fsm.sv
module test_cart_cmd_fsm;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [63:0] cmd_data;
  logic [15:0] cmd_len;
  logic        ext_platform;
  logic [31:0] chip_id;
  logic [15:0] region_field;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [7:0]  rsp_fill;
  logic [31:0] rsp_addr;
  logic [15:0] rsp_len;
  logic [15:0] rsp_span;
  logic [1:0]  mode;
  logic        data_enc;
  logic        key_init;
  logic        key_ext;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cart_cmd_fsm i_cart_cmd_fsm (.*);

  typedef struct packed {
    logic [63:0] cmd;
    logic [15:0] len;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [15:0] rlen;
    logic [15:0] span;
    logic [1:0]  md;
    logic        enc;
  } vec_t;

  localparam int NV = 16;
  // Walks raw -> secure standard -> main, region_field = 1, ext_platform = 0
  localparam vec_t VEC [NV] = '{
    '{64'h9F00_0000_0000_0000, 16'h0200, 2'd1, 32'h0,    16'h0200, 16'h0,    2'd0, 1'b0}, // R3
    '{64'h0000_0000_0000_0000, 16'h2000, 2'd3, 32'h0,    16'h2000, 16'h1000, 2'd0, 1'b0}, // R4
    '{64'h9000_0000_0000_0000, 16'h0004, 2'd2, 32'h0,    16'h0004, 16'h0,    2'd0, 1'b0}, // R5
    '{64'hB800_0000_0000_0000, 16'h0004, 2'd0, 32'h0,    16'h0,    16'h0,    2'd0, 1'b0}, // R5
    '{64'h1200_0000_0000_0000, 16'h0008, 2'd0, 32'h0,    16'h0,    16'h0,    2'd0, 1'b0}, // R8
    '{64'h3C00_0000_0000_0000, 16'h0000, 2'd0, 32'h0,    16'h0,    16'h0,    2'd1, 1'b0}, // R6
    '{64'h4000_0000_0000_0000, 16'h0000, 2'd0, 32'h0,    16'h0,    16'h0,    2'd1, 1'b1}, // R9
    '{64'h1000_0000_0000_0000, 16'h0008, 2'd2, 32'h0,    16'h0008, 16'h0,    2'd1, 1'b1}, // R10
    '{64'h2000_7F00_0000_0000, 16'h0200, 2'd3, 32'h7000, 16'h1000, 16'h1000, 2'd1, 1'b1}, // R10
    '{64'h9F00_0000_0000_0000, 16'h0200, 2'd0, 32'h0,    16'h0,    16'h0,    2'd1, 1'b1}, // R12
    '{64'hA000_0000_0000_0000, 16'h0000, 2'd0, 32'h0,    16'h0,    16'h0,    2'd3, 1'b1}, // R12
    '{64'h9F00_0000_0000_0000, 16'h0200, 2'd0, 32'h0,    16'h0,    16'h0,    2'd3, 1'b1}, // R13
    '{64'h0000_0000_0000_0000, 16'h0200, 2'd0, 32'h0,    16'h0,    16'h0,    2'd3, 1'b1}, // R13
    '{64'h3C00_0000_0000_0000, 16'h0000, 2'd0, 32'h0,    16'h0,    16'h0,    2'd3, 1'b1}, // R13
    '{64'hB800_0000_0000_0000, 16'h0010, 2'd2, 32'h0,    16'h0010, 16'h0,    2'd3, 1'b1}, // R13
    '{64'hA000_0000_0000_0000, 16'h0000, 2'd0, 32'h0,    16'h0,    16'h0,    2'd3, 1'b1}  // R13
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Present one command for one cycle; return at the negedge after acceptance
  task automatic send(input logic [63:0] c, input logic [15:0] l);
    cmd_data  = c;
    cmd_len   = l;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_data = '0; cmd_len = '0;
    ext_platform = 1'b0; chip_id = 32'h5A3C_19E7; region_field = 16'h0001;
    do_reset();

    // R1: reset state
    check("R1", "mode", 32'(mode), 32'd0);
    check("R1", "data_enc", 32'(data_enc), 32'd0);
    check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1", "key_init", 32'(key_init), 32'd0);
    check("R1", "cmd_ready", 32'(cmd_ready), 32'd1);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i].cmd, VEC[i].len);
      check("R2", $sformatf("v%0d rsp_valid", i), 32'(rsp_valid), 32'd1);
      check("R2", $sformatf("v%0d kind", i), 32'(rsp_kind), 32'(VEC[i].kind));
      check("R2", $sformatf("v%0d addr", i), rsp_addr, VEC[i].addr);
      check("R2", $sformatf("v%0d len", i), 32'(rsp_len), 32'(VEC[i].rlen));
      check("R4", $sformatf("v%0d span", i), 32'(rsp_span), 32'(VEC[i].span));
      check("R12", $sformatf("v%0d mode", i), 32'(mode), 32'(VEC[i].md));
      check("R9", $sformatf("v%0d data_enc", i), 32'(data_enc), 32'(VEC[i].enc));
      if (VEC[i].kind == 2'd1)
        check("R3", "fill byte", 32'(rsp_fill), 32'hFF);
    end

    // R2: idle cycle gives no response
    @(negedge clk);
    check("R2", "idle rsp_valid", 32'(rsp_valid), 32'd0);

    // R9: reset clears the sticky flag and main mode
    do_reset();
    check("R9", "enc after reset", 32'(data_enc), 32'd0);
    check("R1", "mode after reset", 32'(mode), 32'd0);

    // R6: key_init pulse, standard variant
    send(64'h3C00_0000_0000_0000, 16'h0);
    check("R6", "key_init", 32'(key_init), 32'd1);
    check("R6", "key_ext", 32'(key_ext), 32'd0);
    check("R6", "mode", 32'(mode), 32'd1);
    @(negedge clk);
    check("R6", "key_init one cycle", 32'(key_init), 32'd0);

    // R7: 0x3D ignored without extended platform
    do_reset();
    send(64'h3D00_0000_0000_0000, 16'h0);
    check("R7", "no-ext kind", 32'(rsp_kind), 32'd0);
    check("R7", "no-ext mode", 32'(mode), 32'd0);
    check("R7", "no-ext key_init", 32'(key_init), 32'd0);

    // R7: 0x3D with extended platform
    ext_platform = 1'b1;
    region_field = 16'h0003;
    send(64'h3D00_0000_0000_0000, 16'h0);
    check("R7", "ext mode", 32'(mode), 32'd2);
    check("R7", "ext key_init", 32'(key_init), 32'd1);
    check("R7", "ext key_ext", 32'(key_ext), 32'd1);

    // R11: 0x5000 - 0x1000 + (3 << 19) = 0x184000
    send(64'h2000_5000_0000_0000, 16'h0040);
    check("R11", "ext addr", rsp_addr, 32'h0018_4000);
    check("R11", "ext len", 32'(rsp_len), 32'h1000);
    check("R11", "ext kind", 32'(rsp_kind), 32'd3);

    // R11: address wraps modulo 2^32 with region 0
    region_field = 16'h0000;
    send(64'h2000_0000_0000_0000, 16'h0040);
    check("R11", "wrap addr", rsp_addr, 32'hFFFF_F000);

    // R10: chip ID in the extended variant
    send(64'h1000_0000_0000_0000, 16'h0020);
    check("R10", "ext chip id kind", 32'(rsp_kind), 32'd2);
    check("R10", "ext chip id len", 32'(rsp_len), 32'h20);

    // R12: extended variant moves to main
    send(64'hA000_0000_0000_0000, 16'h0);
    check("R12", "ext to main", 32'(mode), 32'd3);
    check("R9", "enc still clear", 32'(data_enc), 32'd0);

    // R13: raw chip-ID opcode ignored in main
    send(64'h9000_0000_0000_0000, 16'h0004);
    check("R13", "0x90 in main", 32'(rsp_kind), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule